// File: doc/BRIEF.md
# DS3 Nibble-Parallel Transmit Payload Interface

This block is the payload entry point of a DS3 clear-channel transmitter that runs from its own line clock and is master of the frame. The line-rate bit clock (nominally 44.736 MHz) is its only time base. From it the block makes a nibble clock for the system side, takes in a 4-bit payload nibble once per nibble period and turns the nibbles into a serial DS3 bit stream. One bit time is left free at the head of every payload block for a framing overhead bit, which a later stage fills in. The block marks that slot with a strobe and pulses a frame marker while the last nibble of each frame is being taken in.

The frame is modelled as `BLOCKS` payload blocks, each one overhead slot followed by `PAY_BITS` payload bits. The defaults are 56 blocks of 84 bits: 4760 bit times per frame, 21 nibbles per block and 1176 nibbles per frame. A nibble period is four bit clocks. The period that opens a block lasts five bit clocks because it also holds the overhead slot, so the nibble clock is close to a quarter of the bit clock but not exactly a quarter. The system side has no handshake and cannot apply back-pressure. It must change `nib_in` on the rising edge of `nib_clk` and keep it steady until the block samples it. The block never waits, so a nibble that is late is simply lost.

Top module: `ds3_nib_tx`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `oh_slot` is 1 and `nib_clk`, `frame_mark` and `ser_bit` are 0. The first output slot of the stream is the overhead slot of block 0.
- R2: In every nibble period `nib_clk` is low in the first cycle, high in the second and third cycles and low for the rest of the period.
- R3: The nibble period that opens a block lasts 5 cycles and its first cycle is the overhead slot, with `oh_slot` high for that one cycle only. Every other nibble period lasts 4 cycles. `oh_slot` is high in exactly one cycle out of every `PAY_BITS`+1.
- R4: `nib_in` is sampled at the third rising edge of `clk` after the edge at which `nib_clk` went high, which is the edge that ends the fourth cycle of the period. Values on `nib_in` at any other edge have no effect on the output.
- R5: The nibble sampled in nibble period n is sent in the payload cycles of period n+1, one bit per cycle, bit 3 first. The nibble sent in the first period after reset is 0.
- R6: `ser_bit` is 0 in every overhead slot.
- R7: `frame_mark` is high for exactly the nibble period in which the frame's last nibble is sampled. Counting periods from 0 after reset, this is period `NIB_PER_FRM`-2 of each frame. With the defaults the marker rises 4752 cycles after reset and stays high for 4 cycles.
- R8: A frame is (`PAY_BITS`+1)·`BLOCKS` cycles long and has `BLOCKS`·`PAY_BITS`/4 nibble periods. With the defaults that is 4760 cycles and 1176 rising edges of `nib_clk`, and the marker repeats every 4760 cycles.
- R9: A synchronous reset in the middle of the stream restarts the block at the overhead slot of block 0. Timing, the sampled nibble and the output then behave exactly as after the first reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-rate bit clock, the only timing source |
| rst | input | 1 | Synchronous active-high reset |
| nib_in | input | NIB_W | Payload nibble from the system side |
| nib_clk | output | 1 | Nibble clock to the system side |
| ser_bit | output | 1 | Serial payload bit, 0 in overhead slots |
| oh_slot | output | 1 | High in the bit time kept free for an overhead bit |
| frame_mark | output | 1 | High during the period that samples the frame's last nibble |

## Verification
The hardest corner is the stretched period at the head of each block. A design that forgot to stretch it, or put the free slot at the wrong end of the period, would shift every later payload bit and fail the per-cycle serial comparison within the first block. The bench drives junk on `nib_in` in every cycle except the one just before the sampling edge. A design that sampled one edge early or late, or sampled during the overhead slot, would therefore send complemented nibbles. The bench also checks the marker position and period and the frame length in a full-size instance, which catches an off-by-one in the frame counter. A mid-stream reset catches state that survives the restart, such as a stale hold register or a bit counter that is not cleared.

// File: rtl/ds3tx_pkg.sv
package ds3tx_pkg;

  // Per-cycle control that the slot sequencer hands to the shifter.
  typedef struct packed {
    logic boundary;  // last cycle of the current nibble period
    logic capture;   // sampling edge closes this cycle
    logic payload;   // this cycle carries a payload bit
    logic direct;    // capture and boundary coincide: load straight from input
  } ds3tx_ctl_t;

  // Cycle inside a period at which sampling happens (third edge after rise).
  localparam int unsigned CAP_PHASE = 3;

endpackage

// File: rtl/ds3tx_seq.sv
module ds3tx_seq
  import ds3tx_pkg::*;
#(
  parameter int unsigned NIB_W       = 4,
  parameter int unsigned NIB_PER_BLK = 21,
  parameter int unsigned NIB_PER_FRM = 1176
) (
  input  logic       clk,
  input  logic       rst,
  output ds3tx_ctl_t ctl,
  output logic       nib_clk,
  output logic       oh_slot,
  output logic       frame_mark
);

  localparam int unsigned PH_W = $clog2(NIB_W + 1);
  localparam int unsigned NB_W = (NIB_PER_BLK > 1) ? $clog2(NIB_PER_BLK) : 1;
  localparam int unsigned PI_W = $clog2(NIB_PER_FRM);

  localparam logic [PH_W-1:0] PH_LONG  = PH_W'(NIB_W);
  localparam logic [PH_W-1:0] PH_SHORT = PH_W'(NIB_W - 1);
  localparam logic [PH_W-1:0] PH_CAP   = PH_W'(CAP_PHASE);
  localparam logic [PH_W-1:0] PH_HI0   = PH_W'(1);
  localparam logic [PH_W-1:0] PH_HI1   = PH_W'(2);
  localparam logic [NB_W-1:0] NB_LAST  = NB_W'(NIB_PER_BLK - 1);
  localparam logic [PI_W-1:0] PI_LAST  = PI_W'(NIB_PER_FRM - 1);
  localparam logic [PI_W-1:0] PI_MARK  = PI_W'(NIB_PER_FRM - 2);

  logic [PH_W-1:0] ph_q, ph_n;
  logic [NB_W-1:0] nib_q, nib_n;
  logic [PI_W-1:0] pidx_q, pidx_n;
  logic            stretched;
  logic [PH_W-1:0] last_ph;

  always_comb begin
    stretched    = (nib_q == '0);
    last_ph      = stretched ? PH_LONG : PH_SHORT;
    ctl.boundary = (ph_q == last_ph);
    ctl.capture  = (ph_q == PH_CAP);
    ctl.payload  = !(stretched && (ph_q == '0));
    ctl.direct   = ctl.capture && ctl.boundary;

    ph_n   = ph_q + PH_W'(1);
    nib_n  = nib_q;
    pidx_n = pidx_q;
    if (ctl.boundary) begin
      ph_n   = '0;
      nib_n  = (nib_q == NB_LAST) ? '0 : nib_q + NB_W'(1);
      pidx_n = (pidx_q == PI_LAST) ? '0 : pidx_q + PI_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q       <= '0;
      nib_q      <= '0;
      pidx_q     <= '0;
      nib_clk    <= 1'b0;
      oh_slot    <= 1'b1;
      frame_mark <= 1'b0;
    end else begin
      ph_q       <= ph_n;
      nib_q      <= nib_n;
      pidx_q     <= pidx_n;
      nib_clk    <= (ph_n == PH_HI0) || (ph_n == PH_HI1);
      oh_slot    <= (nib_n == '0) && (ph_n == '0);
      frame_mark <= (pidx_n == PI_MARK);
    end
  end

  // R2
  nib_clk_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(nib_clk) |=> (nib_clk ##1 !nib_clk));

  // R3
  oh_single_chk: assert property (@(posedge clk) disable iff (rst)
    oh_slot |=> !oh_slot);

  // R3
  oh_clk_low_chk: assert property (@(posedge clk) disable iff (rst)
    oh_slot |-> !nib_clk);

  // R7
  mark_align_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_mark) |=> $rose(nib_clk));

endmodule

// File: rtl/ds3tx_shift.sv
module ds3tx_shift
  import ds3tx_pkg::*;
#(
  parameter int unsigned NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NIB_W-1:0] nib_in,
  input  ds3tx_ctl_t       ctl,
  output logic             ser_bit
);

  logic [NIB_W-1:0] hold_q;
  logic [NIB_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      sh_q   <= '0;
    end else begin
      if (ctl.capture) hold_q <= nib_in;
      if (ctl.boundary) begin
        sh_q <= ctl.direct ? nib_in : hold_q;
      end else if (ctl.payload) begin
        sh_q <= {sh_q[NIB_W-2:0], 1'b0};
      end
    end
  end

  assign ser_bit = ctl.payload & sh_q[NIB_W-1];

  // R4
  cap_in_period_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.capture |-> ctl.payload);

endmodule

// File: rtl/ds3_nib_tx.sv
module ds3_nib_tx
  import ds3tx_pkg::*;
#(
  parameter int unsigned PAY_BITS = 84,
  parameter int unsigned BLOCKS   = 56,
  parameter int unsigned NIB_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NIB_W-1:0] nib_in,
  output logic             nib_clk,
  output logic             ser_bit,
  output logic             oh_slot,
  output logic             frame_mark
);

  localparam int unsigned NIB_PER_BLK = PAY_BITS / NIB_W;
  localparam int unsigned NIB_PER_FRM = NIB_PER_BLK * BLOCKS;

  ds3tx_ctl_t ctl;

  ds3tx_seq #(
    .NIB_W      (NIB_W),
    .NIB_PER_BLK(NIB_PER_BLK),
    .NIB_PER_FRM(NIB_PER_FRM)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .nib_clk   (nib_clk),
    .oh_slot   (oh_slot),
    .frame_mark(frame_mark)
  );

  ds3tx_shift #(
    .NIB_W(NIB_W)
  ) u_shift (
    .clk    (clk),
    .rst    (rst),
    .nib_in (nib_in),
    .ctl    (ctl),
    .ser_bit(ser_bit)
  );

  // R6
  oh_no_data_chk: assert property (@(posedge clk) disable iff (rst)
    oh_slot |-> !ser_bit);

  // R4
  cap_clk_low_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.capture |-> !nib_clk);

endmodule

// File: tb/ds3_nib_tx_bench.sv
module ds3_nib_tx_bench;

  localparam int SP = 8;          // small config: payload bits per block
  localparam int SB = 3;          // small config: blocks per frame
  localparam int SBLK = SP + 1;   // 9 cycles per block
  localparam int SFRM = SBLK * SB; // 27 cycles per frame
  localparam int SNB = SP / 4;    // 2 nibbles per block
  localparam int SNPF = SNB * SB; // 6 nibbles per frame

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] nib_in = 4'h0;
  logic s_clk, s_ser, s_oh, s_mark;
  logic f_clk, f_ser, f_oh, f_mark;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ds3_nib_tx #(.PAY_BITS(SP), .BLOCKS(SB), .NIB_W(4)) u_ds3_nib_tx (
    .clk(clk), .rst(rst), .nib_in(nib_in),
    .nib_clk(s_clk), .ser_bit(s_ser), .oh_slot(s_oh), .frame_mark(s_mark)
  );

  ds3_nib_tx u_full (
    .clk(clk), .rst(rst), .nib_in(nib_in),
    .nib_clk(f_clk), .ser_bit(f_ser), .oh_slot(f_oh), .frame_mark(f_mark)
  );

  function automatic logic [3:0] pat(int g);
    return 4'((g * 5 + 9) % 16);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Model of the small instance at cycle t after reset release.
  int m_ph, m_g, m_bit, m_p;
  bit m_oh;
  task automatic model(int t);
    int q, blk, r, j;
    q = t % SFRM;
    blk = q / SBLK;
    r = q % SBLK;
    if (r < 5) begin j = 0; m_ph = r; m_bit = 3 - (r - 1); end
    else begin j = 1; m_ph = r - 5; m_bit = 3 - (r - 5); end
    m_oh = (r == 0);
    m_p = blk * SNB + j;
    m_g = (t / SFRM) * SNPF + m_p;
  endtask

  task automatic check_small(int t);
    logic exp_ser;
    model(t);
    chk(s_oh == m_oh, "R3 oh_slot", int'(s_oh), int'(m_oh));
    chk(s_clk == ((m_ph == 1) || (m_ph == 2)), "R2 nib_clk", int'(s_clk),
        int'((m_ph == 1) || (m_ph == 2)));
    chk(s_mark == (m_p == SNPF - 2), "R7 frame_mark", int'(s_mark), int'(m_p == SNPF - 2));
    if (m_oh) exp_ser = 1'b0;
    else if (m_g == 0) exp_ser = 1'b0;
    else exp_ser = pat(m_g - 1)[m_bit];
    chk(s_ser == exp_ser, m_oh ? "R6 ser_bit in overhead" : "R4/R5 ser_bit",
        int'(s_ser), int'(exp_ser));
    // Drive: valid only in the cycle that ends at the sampling edge, junk otherwise.
    nib_in = (m_ph == 3) ? pat(m_g) : ~pat(m_g);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    int rise0, rise1, hi_len, oh_cnt, clk_rises;
    bit fm_prev, fc_prev, hi_counting, hi_done;
    rise0 = -1; rise1 = -1; hi_len = 0; oh_cnt = 0; clk_rises = 0;
    fm_prev = 0; fc_prev = 0; hi_counting = 0; hi_done = 0;

    repeat (3) @(negedge clk);
    // R1 during reset
    chk(s_oh == 1'b1, "R1 oh_slot in reset", int'(s_oh), 1);
    chk(s_clk == 1'b0, "R1 nib_clk in reset", int'(s_clk), 0);
    chk(s_mark == 1'b0, "R1 frame_mark in reset", int'(s_mark), 0);
    chk(s_ser == 1'b0, "R1 ser_bit in reset", int'(s_ser), 0);
    rst = 1'b0;

    for (int t = 0; t < 9700; t++) begin
      if (t < 4 * SFRM) check_small(t);
      else nib_in = pat(t);
      if (t == 0) chk(f_oh == 1'b1 && f_clk == 1'b0, "R1 full first slot",
                      int'({f_oh, f_clk}), 2);
      if (t < 4760 && f_oh) oh_cnt++;
      if (t < 4760 && f_clk && !fc_prev) clk_rises++;
      if (f_mark && !fm_prev) begin
        if (rise0 < 0) begin rise0 = t; hi_counting = 1; end
        else if (rise1 < 0) rise1 = t;
      end
      if (hi_counting && !hi_done) begin
        if (f_mark) hi_len++;
        else if (fm_prev) hi_done = 1;
      end
      fm_prev = f_mark;
      fc_prev = f_clk;
      @(negedge clk);
    end

    chk(rise0 == 4752, "R7 first marker cycle", rise0, 4752);
    chk(hi_len == 4, "R7 marker length", hi_len, 4);
    chk(rise1 - rise0 == 4760, "R8 marker spacing", rise1 - rise0, 4760);
    chk(oh_cnt == 56, "R3 overhead slots per frame", oh_cnt, 56);
    chk(clk_rises == 1176, "R8 nibble periods per frame", clk_rises, 1176);

    // R9: reset in the middle of the stream
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(s_oh == 1'b1 && s_clk == 1'b0 && s_mark == 1'b0 && s_ser == 1'b0,
        "R9 state during mid reset", int'({s_oh, s_clk, s_mark, s_ser}), 8);
    rst = 1'b0;
    for (int t = 0; t < 3 * SFRM; t++) begin
      check_small(t);
      @(negedge clk);
    end
    chk(1'b1, "R9 restart sweep done", 0, 0);
    finish_run();
  end

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      finish_run();
    end
  end

endmodule